// File: doc/BRIEF.md
# Word-Interleaved Block Read Controller

This block serves cache-line fills from a memory split into several banks that are interleaved by word. Word address A lives in bank `A mod NUM_BANKS`, at row `A / NUM_BANKS` inside that bank. A read request names one word address. The controller fetches the whole aligned block that contains that word, one word from every bank.

The row is broadcast to all banks in a single address cycle, so every bank runs its fixed-latency access in parallel. The words then leave one per cycle over a single data-word bus. The requested word goes first, and the rest follow in ascending bank order with wrap-around. With the default four banks and six access cycles, a block costs 1 + 6 + 4 = 11 cycles, where a memory that serves one word at a time would need four full accesses.

Each bank is a synchronous array with a fixed access pipeline. The controller keeps one busy bit per bank. It holds off new requests until every bank has handed over its word, and it reports the measured latency together with the last word. A single-word write port loads the banks while no read is in flight.

Top module: `ilv_block_reader`

## Requirements
- R1: After reset, rd_valid, rd_last and all bank_busy bits are 0, and req_ready and wr_ready are 1.
- R2: A word address A selects bank A mod NUM_BANKS (the low address bits) and row A / NUM_BANKS (the upper bits), so the word written at A is the word read back for A.
- R3: For a request at address A, the words returned are those at addresses B + ((A mod NUM_BANKS + k) mod NUM_BANKS) for k = 0 .. NUM_BANKS-1, in that order, where B is A rounded down to a multiple of NUM_BANKS.
- R4: Call the clock edge that accepts a request (req_valid and req_ready both 1) edge 0. Word k is on rd_data with rd_valid high from edge 2 + ACCESS_LAT + k, for NUM_BANKS contiguous cycles. rd_last is high only with the final word.
- R5: While rd_last is high, rd_latency equals 1 + ACCESS_LAT + NUM_BANKS, which is 11 with the defaults.
- R6: From edge 0, every bank_busy bit is 1. The bit of a bank clears at the edge where that bank's word is placed on rd_data.
- R7: req_ready is 0 while any bank is busy, so a request presented then is not taken. A held request is accepted at the first edge after the last word has appeared, which is edge 1 + ACCESS_LAT + NUM_BANKS + 1 after the previous accept.
- R8: A write (wr_en) takes effect only while wr_ready is 1. wr_ready follows req_ready, so a write presented during a read in flight is ignored, and later reads return the old word.
- R9: A write and a read request accepted at the same edge are both performed, and the read returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Block read request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Word address of the requested word |
| wr_en | input | 1 | Single-word write strobe |
| wr_ready | output | 1 | Write is taken this cycle |
| wr_addr | input | ADDR_W | Word address to write |
| wr_data | input | DATA_W | Word to write |
| rd_valid | output | 1 | rd_data carries a returned word |
| rd_data | output | DATA_W | Returned word |
| rd_last | output | 1 | Final word of the block |
| rd_latency | output | LAT_W | Cycles from accept to last word, valid with rd_last |
| bank_busy | output | NUM_BANKS | Per-bank busy state |

## Verification
Counting from the accepting edge, the first word is due 8 edges later, the last word and the latency value are due 11 edges later, and the busy bit of the bank carrying word k drops at edge 8 + k. Request and write readiness return in the cycle that follows the last word. The bench model keeps an age counter that advances at every rising edge from the accept. At each falling edge it derives from that age the expected valid, last, data, busy, ready and latency values, and compares them with the outputs. Writes during a read and writes that coincide with an accept are checked through the data of later reads.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_XFER   = 2'd3
  } seq_state_t;

endpackage

// File: rtl/ilv_addr_split.sv
module ilv_addr_split #(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 4
) (
  input  logic [ADDR_W-1:0]                    word_addr,
  output logic [$clog2(NUM_BANKS)-1:0]         bank_sel,
  output logic [ADDR_W-$clog2(NUM_BANKS)-1:0]  bank_row
);
  localparam int BANK_BITS = $clog2(NUM_BANKS);

  // Low bits pick the bank (modulo), upper bits are the row (divide).
  assign bank_sel = word_addr[BANK_BITS-1:0];
  assign bank_row = word_addr[ADDR_W-1:BANK_BITS];

endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DATA_W     = 32,
  parameter int ROW_W      = 8,
  parameter int ACCESS_LAT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_issue,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ROW_W-1:0]  row_q;
  logic              iss_q;
  logic [ACCESS_LAT-1:0] stg_v;
  logic [DATA_W-1:0] stg_d [ACCESS_LAT];

  // Write port of the array.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
  end

  // Address capture (the shared address cycle).
  always_ff @(posedge clk) begin
    if (rd_issue) row_q <= rd_row;
  end

  // Registered read followed by the rest of the access pipeline.
  // A stage only loads when the stage before it is valid, so the
  // final stage keeps its word until the next access.
  always_ff @(posedge clk) begin
    if (iss_q) stg_d[0] <= mem[row_q];
    for (int i = 1; i < ACCESS_LAT; i++) begin
      if (stg_v[i-1]) stg_d[i] <= stg_d[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_q <= 1'b0;
      stg_v <= '0;
    end else begin
      iss_q    <= rd_issue;
      stg_v[0] <= iss_q;
      for (int i = 1; i < ACCESS_LAT; i++) begin
        stg_v[i] <= stg_v[i-1];
      end
    end
  end

  assign rd_data = stg_d[ACCESS_LAT-1];
  assign rd_done = stg_v[ACCESS_LAT-1];

  // R4: each access completes as a single-cycle pulse.
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);

endmodule

// File: rtl/ilv_sequencer.sv
module ilv_sequencer
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int ROW_W      = 8,
  parameter int ACCESS_LAT = 6,
  parameter int LAT_W      = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [$clog2(NUM_BANKS)-1:0]  req_bank,
  input  logic [ROW_W-1:0]              req_row,
  output logic                          req_ready,
  output logic                          bank_issue,
  output logic [ROW_W-1:0]              issue_row,
  input  logic [NUM_BANKS-1:0]          bank_done,
  output logic                          load_word,
  output logic [$clog2(NUM_BANKS)-1:0]  sel_bank,
  output logic                          last_word,
  output logic [NUM_BANKS-1:0]          bank_busy,
  output logic [LAT_W-1:0]              rd_latency
);
  localparam int BANK_BITS = $clog2(NUM_BANKS);
  localparam logic [LAT_W-1:0] FULL_LAT = LAT_W'(1 + ACCESS_LAT + NUM_BANKS);
  localparam logic [BANK_BITS-1:0] LAST_IDX = BANK_BITS'(NUM_BANKS - 1);

  seq_state_t           state;
  logic [BANK_BITS-1:0] start_q;
  logic [BANK_BITS-1:0] idx_q;
  logic [ROW_W-1:0]     row_q;
  logic [LAT_W-1:0]     lat_cnt;
  logic                 accept;
  logic                 all_done;

  assign req_ready  = (state == ST_IDLE) && (bank_busy == '0);
  assign accept     = req_valid && req_ready;
  assign all_done   = &bank_done;
  assign bank_issue = (state == ST_ADDR);
  assign issue_row  = row_q;
  assign load_word  = ((state == ST_ACCESS) && all_done) || (state == ST_XFER);
  assign sel_bank   = start_q + idx_q;
  assign last_word  = load_word && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      start_q    <= '0;
      idx_q      <= '0;
      row_q      <= '0;
      bank_busy  <= '0;
      lat_cnt    <= '0;
      rd_latency <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_ADDR;
            start_q   <= req_bank;
            row_q     <= req_row;
            idx_q     <= '0;
            bank_busy <= '1;
            lat_cnt   <= LAT_W'(1);
          end
        end
        ST_ADDR:   state <= ST_ACCESS;
        ST_ACCESS: if (all_done) state <= ST_XFER;
        ST_XFER:   if (last_word) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
      if (state != ST_IDLE) lat_cnt <= lat_cnt + 1'b1;
      if (load_word) begin
        idx_q               <= idx_q + 1'b1;
        bank_busy[sel_bank] <= 1'b0;
      end
      if (last_word) rd_latency <= lat_cnt;
    end
  end

  // R4: all banks finish their shared access together.
  p_lockstep_r4: assert property (@(posedge clk) disable iff (rst)
    (|bank_done) |-> (&bank_done));

  // R4: bank completion only arrives while the sequencer waits for it.
  p_done_in_access_r4: assert property (@(posedge clk) disable iff (rst)
    (|bank_done) |-> (state == ST_ACCESS));

  // R6: busy bits are released one bank per cycle.
  p_single_release_r6: assert property (@(posedge clk) disable iff (rst)
    $countones($past(bank_busy) & ~bank_busy) <= 1);

  // R5: the reported latency matches the full block time.
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    last_word |=> (rd_latency == FULL_LAT));

endmodule

// File: rtl/ilv_return_mux.sv
module ilv_return_mux #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_data,
  input  logic [$clog2(NUM_BANKS)-1:0]      sel_bank,
  input  logic                              load_word,
  input  logic                              last_word,
  output logic                              rd_valid,
  output logic [DATA_W-1:0]                 rd_data,
  output logic                              rd_last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= load_word;
      rd_last  <= load_word && last_word;
      if (load_word) rd_data <= bank_data[sel_bank];
    end
  end

  // R4: the last flag only accompanies a valid word.
  p_last_valid_r4: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);

  // R4: the burst is contiguous until the last word.
  p_burst_run_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_last) |=> rd_valid);

endmodule

// File: rtl/ilv_block_reader.sv
module ilv_block_reader #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int NUM_BANKS  = 4,
  parameter int ACCESS_LAT = 6,
  parameter int LAT_W      = $clog2(ACCESS_LAT + NUM_BANKS + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 wr_en,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_last,
  output logic [LAT_W-1:0]     rd_latency,
  output logic [NUM_BANKS-1:0] bank_busy
);
  localparam int BANK_BITS = $clog2(NUM_BANKS);
  localparam int ROW_W     = ADDR_W - BANK_BITS;

  logic [BANK_BITS-1:0]             req_bank, wr_bank, sel_bank;
  logic [ROW_W-1:0]                 req_row, wr_row, issue_row;
  logic                             bank_issue, load_word, last_word;
  logic [NUM_BANKS-1:0]             bank_done;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data;
  logic                             wr_take;

  ilv_addr_split #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_req_split (
    .word_addr (req_addr),
    .bank_sel  (req_bank),
    .bank_row  (req_row)
  );

  ilv_addr_split #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_wr_split (
    .word_addr (wr_addr),
    .bank_sel  (wr_bank),
    .bank_row  (wr_row)
  );

  ilv_sequencer #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W),
    .ACCESS_LAT(ACCESS_LAT), .LAT_W(LAT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_bank   (req_bank),
    .req_row    (req_row),
    .req_ready  (req_ready),
    .bank_issue (bank_issue),
    .issue_row  (issue_row),
    .bank_done  (bank_done),
    .load_word  (load_word),
    .sel_bank   (sel_bank),
    .last_word  (last_word),
    .bank_busy  (bank_busy),
    .rd_latency (rd_latency)
  );

  assign wr_ready = req_ready;
  assign wr_take  = wr_en && wr_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W), .ACCESS_LAT(ACCESS_LAT)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_take && (wr_bank == BANK_BITS'(b))),
      .wr_row   (wr_row),
      .wr_data  (wr_data),
      .rd_issue (bank_issue),
      .rd_row   (issue_row),
      .rd_data  (bank_data[b]),
      .rd_done  (bank_done[b])
    );
  end

  ilv_return_mux #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .bank_data (bank_data),
    .sel_bank  (sel_bank),
    .load_word (load_word),
    .last_word (last_word),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_last   (rd_last)
  );

  // R7: no new request is taken while the burst is still running.
  p_hold_off_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_last) |-> !req_ready);

endmodule

// File: tb/ilv_block_reader_test.sv
module ilv_block_reader_test;
  localparam int ADDR_W     = 10;
  localparam int DATA_W     = 32;
  localparam int NB         = 4;
  localparam int ACCESS_LAT = 6;
  localparam int LAT_W      = $clog2(ACCESS_LAT + NB + 2);
  localparam int WORDS      = 1 << ADDR_W;
  localparam int FIRST_AGE  = 2 + ACCESS_LAT;
  localparam int LAST_AGE   = 1 + ACCESS_LAT + NB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic req_ready, wr_ready, rd_valid, rd_last;
  logic [DATA_W-1:0] rd_data;
  logic [LAT_W-1:0] rd_latency;
  logic [NB-1:0] bank_busy;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic done = 1'b0;

  logic [DATA_W-1:0] ref_mem [WORDS];
  int age = -1;
  int mstart = 0;
  int mbase = 0;
  logic [DATA_W-1:0] first_word = '0;

  ilv_block_reader #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NB), .ACCESS_LAT(ACCESS_LAT)
  ) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .wr_en(wr_en), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .rd_latency(rd_latency), .bank_busy(bank_busy)
  );

  always #10 clk = ~clk;

  function automatic logic [DATA_W-1:0] pat(input int a);
    return (DATA_W'(a) * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: age counts edges since the accepting edge.
  always @(posedge clk) begin
    bit idle;
    if (rst) begin
      age = -1;
    end else begin
      idle = (age < 0) || (age >= LAST_AGE);
      if (idle) begin
        if (wr_en) ref_mem[wr_addr] = wr_data;
        if (req_valid) begin
          age    = 0;
          mstart = int'(req_addr) % NB;
          mbase  = int'(req_addr) / NB;
        end else begin
          age = -1;
        end
      end else begin
        age = age + 1;
      end
    end
  end

  // Per-cycle comparison at the falling edge.
  always @(negedge clk) begin
    bit exp_valid, exp_last, exp_ready;
    logic [NB-1:0] exp_busy;
    logic [DATA_W-1:0] exp_data;
    if (!rst && !done) begin
      exp_valid = (age >= FIRST_AGE) && (age <= LAST_AGE);
      exp_last  = (age == LAST_AGE);
      exp_ready = (age < 0) || (age >= LAST_AGE);
      for (int b = 0; b < NB; b++) begin
        int kb;
        kb = (b - mstart + NB) % NB;
        exp_busy[b] = (age >= 0) && (age <= LAST_AGE) && (age < FIRST_AGE + kb);
      end
      check(rd_valid == exp_valid, "R4 rd_valid", DATA_W'(rd_valid), DATA_W'(exp_valid));
      check(rd_last == exp_last, "R4 rd_last", DATA_W'(rd_last), DATA_W'(exp_last));
      check(bank_busy == exp_busy, "R6 bank_busy", DATA_W'(bank_busy), DATA_W'(exp_busy));
      check(req_ready == exp_ready, "R7 req_ready", DATA_W'(req_ready), DATA_W'(exp_ready));
      check(wr_ready == exp_ready, "R8 wr_ready", DATA_W'(wr_ready), DATA_W'(exp_ready));
      if (exp_valid) begin
        exp_data = ref_mem[mbase * NB + ((mstart + age - FIRST_AGE) % NB)];
        check(rd_data == exp_data, "R3 rd_data order", rd_data, exp_data);
        if (age == FIRST_AGE) first_word = rd_data;
      end
      if (exp_last)
        check(rd_latency == LAT_W'(LAST_AGE), "R5 rd_latency",
              DATA_W'(rd_latency), DATA_W'(LAST_AGE));
    end
  end

  task automatic read_req(input int a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(a);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(rd_valid == 1'b0 && rd_last == 1'b0, "R1 rd_valid/rd_last",
          DATA_W'({rd_valid, rd_last}), '0);
    check(bank_busy == '0, "R1 bank_busy", DATA_W'(bank_busy), '0);
    check(req_ready && wr_ready, "R1 ready", DATA_W'({req_ready, wr_ready}), 32'h3);

    // Preload every word through the single-word port.
    for (int a = 0; a < WORDS; a++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = ADDR_W'(a);
      wr_data = pat(a);
    end
    @(negedge clk);
    wr_en = 1'b0;

    // Every starting bank, and the top of the address space.
    for (int a = 0; a < NB; a++) begin
      read_req(a);
      wait_idle();
    end
    read_req(WORDS - 1);
    wait_idle();
    // R2: bank 3, row 255 holds address 1023
    check(first_word == pat(WORDS - 1), "R2 address split", first_word, pat(WORDS - 1));
    read_req(513);
    wait_idle();
    check(first_word == pat(513), "R2 mid address", first_word, pat(513));

    // R7: back-to-back requests held off while banks are busy.
    read_req(5);
    read_req(6);
    read_req(7);
    read_req(200);
    wait_idle();

    // R8: a write during a read in flight is ignored.
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(40);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(41);
    wr_data = 32'hDEADBEEF;
    @(negedge clk);
    wr_en = 1'b0;
    wait_idle();
    read_req(41);
    wait_idle();
    check(first_word == pat(41), "R8 write while busy ignored", first_word, pat(41));

    // R9: write and read accepted on the same edge.
    @(negedge clk);
    wr_en     = 1'b1;
    wr_addr   = ADDR_W'(66);
    wr_data   = 32'h12345678;
    req_valid = 1'b1;
    req_addr  = ADDR_W'(66);
    @(negedge clk);
    wr_en     = 1'b0;
    req_valid = 1'b0;
    wait_idle();
    check(first_word == 32'h12345678, "R9 same-edge write seen by read",
          first_word, 32'h12345678);

    finish_run();
  end

endmodule